// File: doc/BRIEF.md
# Lockdown-Aware Cache Victim Selector

This block chooses which way of a four-way set-associative cache receives a new line on a fill. Software can pin ways by setting their lock bits in a 32-bit lockdown register; a locked way is never chosen while any other way is free. Among the free ways the block applies either a round-robin or a pseudo-random policy, chosen per fill by a policy input. If every way is locked, the fill goes to way 0.

Software reaches the lockdown register through a single-cycle request port. Each request carries a privilege flag and a security-world flag. A configuration input says whether the non-secure world may use lockdown. Requests that are not allowed are refused with a fault strobe. A refused write changes nothing, and a refused read returns zero. Ways above the implemented count (parameter `NUM_WAYS`, 1 to 4) always read as locked.

Top module: `lockdown_victim_sel`

## Requirements
- R1: Register bits [3:0] are the lock bits, with bit n belonging to way n. A permitted write loads them from write data bits [3:0], and a permitted read returns them in bits [3:0].
- R2: When at least one way is unlocked, the way chosen for a fill is never a way whose lock bit is 1.
- R3: After reset, every implemented lock bit is 0, no response or victim strobe is active, and the first round-robin fill chooses way 0.
- R4: With policy_rr=1, the block scans upward from the way after the last round-robin victim, wrapping from 3 to 0, and takes the first unlocked way. Only round-robin fills move this pointer.
- R5: With policy_rr=0, the scan starts at the two low bits of a 16-bit LFSR and moves upward, wrapping, to the first unlocked way. The LFSR is loaded with 0xACE1 while reset is held. On every clock after reset it shifts left, and its new bit 0 is the XOR of bits 15, 13, 12 and 10.
- R6: When all four lock bits are 1, under either policy, the victim is way 0.
- R7: The lock bit of every way numbered NUM_WAYS or higher reads as 1, and writes to it have no effect.
- R8: Write data bits [31:4] have no effect, and a permitted read returns ones in bits [31:4].
- R9: An access with ctx_priv=0 always faults. A privileged secure access (ctx_nonsecure=0) never faults. A privileged non-secure access faults exactly when ns_lock_en=0.
- R10: A faulting write leaves the lock bits unchanged. Every faulting response carries reg_rdata=0, and so does every permitted write.
- R11: reg_rsp_valid and its fault and data come one cycle after reg_en. victim_valid and victim_way come one cycle after fill_req. A fill sampled on the clock edge after a permitted write already sees the new lock bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_en | input | 1 | Register access request, one cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_wdata | input | 32 | Write data |
| ctx_priv | input | 1 | Requester is privileged |
| ctx_nonsecure | input | 1 | Requester is in the non-secure world |
| ns_lock_en | input | 1 | Non-secure world may access lockdown |
| reg_rsp_valid | output | 1 | Response strobe |
| reg_rsp_fault | output | 1 | Access refused (undefined-instruction fault) |
| reg_rdata | output | 32 | Read data |
| fill_req | input | 1 | Line fill needs a victim |
| policy_rr | input | 1 | 1 = round-robin, 0 = pseudo-random |
| victim_valid | output | 1 | Victim strobe |
| victim_way | output | 2 | Chosen way |

## Verification
The assertions assume that every input holds a defined 0 or 1 after reset and changes only between rising edges. For the victim properties they use the lock bits from the previous cycle, so a write and a fill in the same cycle are also covered. The bench drives every input on the falling edge, keeps the whole bus at known values even when idle, and lets context, policy and write data vary freely within those limits. A second instance with three implemented ways runs beside the first on the same stimulus.

// File: rtl/lvs_pkg.sv
package lvs_pkg;
  localparam int unsigned LD_WAYS  = 4;
  localparam int unsigned LD_IDX_W = 2;
  localparam int unsigned LD_REG_W = 32;
  localparam int unsigned LFSR_W   = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  typedef logic [LD_WAYS-1:0]  lock_vec_t;
  typedef logic [LD_IDX_W-1:0] way_idx_t;

  // Permission check for one lockdown register access
  function automatic logic access_ok(input logic priv, input logic nonsec,
                                     input logic ns_en);
    return priv && (!nonsec || ns_en);
  endfunction

  // First unlocked way at or above start (wrapping); way 0 when none is free
  function automatic way_idx_t scan_unlocked(input way_idx_t start,
                                             input lock_vec_t mask);
    way_idx_t res;
    logic     found;
    res   = '0;
    found = 1'b0;
    for (int i = 0; i < LD_WAYS; i++) begin
      way_idx_t cand;
      cand = start + way_idx_t'(i);
      if (!found && !mask[cand]) begin
        res   = cand;
        found = 1'b1;
      end
    end
    return res;
  endfunction

  // Left-shift LFSR step, taps 15,13,12,10
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/lvs_reg_port.sv
module lvs_reg_port
  import lvs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_en,
  input  logic                reg_we,
  input  logic                ctx_priv,
  input  logic                ctx_nonsecure,
  input  logic                ns_lock_en,
  input  lock_vec_t           lock_mask,
  output logic                acc_ok,
  output logic                wr_commit,
  output logic                rsp_valid,
  output logic                rsp_fault,
  output logic [LD_REG_W-1:0] rsp_rdata
);
  localparam int unsigned PAD_W = LD_REG_W - LD_WAYS;

  assign acc_ok    = access_ok(ctx_priv, ctx_nonsecure, ns_lock_en);
  assign wr_commit = reg_en && reg_we && acc_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= reg_en;
      rsp_fault <= reg_en && !acc_ok;
      if (reg_en && !reg_we && acc_ok)
        rsp_rdata <= {{PAD_W{1'b1}}, lock_mask};
      else
        rsp_rdata <= '0;
    end
  end
endmodule

// File: rtl/lvs_lock_reg.sv
module lvs_lock_reg
  import lvs_pkg::*;
#(
  parameter int unsigned NUM_WAYS = LD_WAYS
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_commit,
  input  lock_vec_t wr_bits,
  output lock_vec_t lock_mask
);
  for (genvar g = 0; g < LD_WAYS; g++) begin : g_way
    if (g < NUM_WAYS) begin : g_impl
      logic bit_q;
      always_ff @(posedge clk) begin
        if (!rst_n)         bit_q <= 1'b0;
        else if (wr_commit) bit_q <= wr_bits[g];
      end
      assign lock_mask[g] = bit_q;
    end else begin : g_absent
      assign lock_mask[g] = 1'b1;
    end
  end
endmodule

// File: rtl/lvs_lfsr.sv
module lvs_lfsr
  import lvs_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = LFSR_SEED
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [LFSR_W-1:0] state
);
  always_ff @(posedge clk) begin
    if (!rst_n) state <= SEED;
    else        state <= lfsr_next(state);
  end
endmodule

// File: rtl/lvs_victim_pick.sv
module lvs_victim_pick
  import lvs_pkg::*;
(
  input  lock_vec_t lock_mask,
  input  logic      policy_rr,
  input  way_idx_t  rr_last,
  input  way_idx_t  rnd_start,
  output way_idx_t  pick,
  output logic      all_locked
);
  way_idx_t start;
  assign start      = policy_rr ? (rr_last + way_idx_t'(1)) : rnd_start;
  assign all_locked = &lock_mask;
  assign pick       = all_locked ? '0 : scan_unlocked(start, lock_mask);
endmodule

// File: rtl/lockdown_victim_sel.sv
module lockdown_victim_sel
  import lvs_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_en,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  input  logic        ctx_priv,
  input  logic        ctx_nonsecure,
  input  logic        ns_lock_en,
  output logic        reg_rsp_valid,
  output logic        reg_rsp_fault,
  output logic [31:0] reg_rdata,
  input  logic        fill_req,
  input  logic        policy_rr,
  output logic        victim_valid,
  output logic [1:0]  victim_way
);
  // Named internal events, observed by the bound checker
  lock_vec_t         lock_mask;
  logic              acc_ok;
  logic              wr_commit;
  logic              all_locked;
  way_idx_t          pick;
  way_idx_t          rr_last;
  logic [LFSR_W-1:0] lfsr_q;
  logic              unused_wdata_hi;

  // Bits above the lock field have no function
  assign unused_wdata_hi = ^reg_wdata[LD_REG_W-1:LD_WAYS];

  lvs_reg_port u_port (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .ctx_priv(ctx_priv), .ctx_nonsecure(ctx_nonsecure), .ns_lock_en(ns_lock_en),
    .lock_mask(lock_mask), .acc_ok(acc_ok), .wr_commit(wr_commit),
    .rsp_valid(reg_rsp_valid), .rsp_fault(reg_rsp_fault), .rsp_rdata(reg_rdata)
  );

  lvs_lock_reg #(.NUM_WAYS(NUM_WAYS)) u_lock (
    .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit),
    .wr_bits(reg_wdata[LD_WAYS-1:0]), .lock_mask(lock_mask)
  );

  lvs_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .state(lfsr_q)
  );

  lvs_victim_pick u_pick (
    .lock_mask(lock_mask), .policy_rr(policy_rr), .rr_last(rr_last),
    .rnd_start(lfsr_q[LD_IDX_W-1:0]), .pick(pick), .all_locked(all_locked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_last      <= way_idx_t'(LD_WAYS - 1);
      victim_valid <= 1'b0;
      victim_way   <= '0;
    end else begin
      victim_valid <= fill_req;
      if (fill_req) victim_way <= pick;
      if (fill_req && policy_rr) rr_last <= pick;
    end
  end
endmodule

// File: rtl/lockdown_victim_sel_chk.sv
module lockdown_victim_sel_chk
  import lvs_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                reg_en,
  input logic                reg_we,
  input logic                ctx_priv,
  input logic                ctx_nonsecure,
  input logic                reg_rsp_valid,
  input logic                reg_rsp_fault,
  input logic [LD_REG_W-1:0] reg_rdata,
  input logic                fill_req,
  input logic                policy_rr,
  input logic                victim_valid,
  input way_idx_t            victim_way,
  input lock_vec_t           lock_mask,
  input logic                acc_ok,
  input way_idx_t            rr_last
);
  lock_vec_t lock_q;
  always_ff @(posedge clk) lock_q <= lock_mask;

  p_victim_unlocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid && (lock_q != 4'hF) |-> !lock_q[victim_way]);

  p_all_locked_way0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && (lock_mask == 4'hF) |=> victim_valid && (victim_way == 2'd0));

  p_rr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && policy_rr && (lock_mask == 4'h0) |=>
      victim_way == $past(rr_last) + 2'd1);

  p_user_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en && !ctx_priv |=> reg_rsp_fault);

  p_secure_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en && ctx_priv && !ctx_nonsecure |=> !reg_rsp_fault);

  p_fault_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en && reg_we && !acc_ok |=> $stable(lock_mask));

  p_fault_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rsp_fault |-> reg_rdata == '0);

  p_upper_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en && !reg_we && acc_ok |=> reg_rdata[LD_REG_W-1:LD_WAYS] == '1);

  p_rsp_timing_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en |=> reg_rsp_valid);

  p_fill_timing_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |=> victim_valid);
endmodule

bind lockdown_victim_sel lockdown_victim_sel_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
  .ctx_priv(ctx_priv), .ctx_nonsecure(ctx_nonsecure),
  .reg_rsp_valid(reg_rsp_valid), .reg_rsp_fault(reg_rsp_fault),
  .reg_rdata(reg_rdata), .fill_req(fill_req), .policy_rr(policy_rr),
  .victim_valid(victim_valid), .victim_way(victim_way),
  .lock_mask(lock_mask), .acc_ok(acc_ok), .rr_last(rr_last)
);

// File: tb/lockdown_victim_sel_tb_top.sv
module lockdown_victim_sel_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_en = 1'b0, reg_we = 1'b0, ctx_priv = 1'b0, ctx_nonsecure = 1'b0;
  logic ns_lock_en = 1'b0, fill_req = 1'b0, policy_rr = 1'b0;
  logic [31:0] reg_wdata = '0;

  logic        rv[2], rf[2], vv[2];
  logic [31:0] rd[2];
  logic [1:0]  vw[2];

  lockdown_victim_sel dut_i (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .ctx_priv(ctx_priv), .ctx_nonsecure(ctx_nonsecure), .ns_lock_en(ns_lock_en),
    .reg_rsp_valid(rv[0]), .reg_rsp_fault(rf[0]), .reg_rdata(rd[0]),
    .fill_req(fill_req), .policy_rr(policy_rr), .victim_valid(vv[0]), .victim_way(vw[0]));

  lockdown_victim_sel #(.NUM_WAYS(3)) dut3_i (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .ctx_priv(ctx_priv), .ctx_nonsecure(ctx_nonsecure), .ns_lock_en(ns_lock_en),
    .reg_rsp_valid(rv[1]), .reg_rsp_fault(rf[1]), .reg_rdata(rd[1]),
    .fill_req(fill_req), .policy_rr(policy_rr), .victim_valid(vv[1]), .victim_way(vw[1]));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_lfsr;
  logic [3:0]  m_lock[2];
  logic [1:0]  m_rr[2];
  logic [3:0]  absent[2];

  // Reference LFSR per R5, written as a masked parity
  function automatic logic [15:0] b_step(input logic [15:0] s);
    return {s[14:0], ^(s & 16'hB400)};
  endfunction

  function automatic logic [1:0] b_pick(input logic [1:0] st, input logic [3:0] m);
    int w = st;
    repeat (4) begin
      if (!m[w]) return 2'(w);
      w = (w + 1) % 4;
    end
    return 2'd0;
  endfunction

  always @(posedge clk) m_lfsr <= !rst_n ? 16'hACE1 : b_step(m_lfsr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic reg_op(input logic we, input logic [31:0] wd, input logic pv,
                        input logic ns, input logic nse, input string req);
    logic ok;
    logic [31:0] exp_rd[2];
    ok = pv && (!ns || nse);
    for (int d = 0; d < 2; d++) begin
      exp_rd[d] = (ok && !we) ? {28'hFFFFFFF, m_lock[d]} : 32'h0;
      if (ok && we) m_lock[d] = wd[3:0] | absent[d];
    end
    reg_en = 1'b1; reg_we = we; reg_wdata = wd;
    ctx_priv = pv; ctx_nonsecure = ns; ns_lock_en = nse;
    @(negedge clk);
    reg_en = 1'b0;
    for (int d = 0; d < 2; d++) begin
      chk({req, " R11 rsp_valid"}, 32'(rv[d]), 32'd1);
      chk({req, " R9 fault"}, 32'(rf[d]), 32'(!ok));
      chk({req, " R10 rdata"}, rd[d], exp_rd[d]);
    end
  endtask

  task automatic fill_op(input logic rr, input string req);
    logic [1:0] exp_w[2];
    for (int d = 0; d < 2; d++) begin
      exp_w[d] = b_pick(rr ? m_rr[d] + 2'd1 : m_lfsr[1:0], m_lock[d]);
      if (rr) m_rr[d] = exp_w[d];
    end
    fill_req = 1'b1; policy_rr = rr;
    @(negedge clk);
    fill_req = 1'b0;
    for (int d = 0; d < 2; d++) begin
      chk({req, " R11 victim_valid"}, 32'(vv[d]), 32'd1);
      chk({req, " victim_way"}, 32'(vw[d]), 32'(exp_w[d]));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL R11 watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1176));
    absent[0] = 4'h0; absent[1] = 4'h8;
    for (int d = 0; d < 2; d++) begin m_lock[d] = absent[d]; m_rr[d] = 2'd3; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int d = 0; d < 2; d++) begin
      chk("R3 rsp idle", 32'(rv[d]), 32'd0);
      chk("R3 victim idle", 32'(vv[d]), 32'd0);
    end
    reg_op(1'b0, 32'h0, 1'b1, 1'b0, 1'b0, "R3 R7 reset read");
    repeat (5) fill_op(1'b1, "R3 R4 rr unlocked");
    reg_op(1'b1, 32'h0000_0005, 1'b1, 1'b0, 1'b0, "R1 R8 write 0101");
    fill_op(1'b1, "R11 fill right after write R2");
    repeat (3) fill_op(1'b1, "R2 R4 rr skip locked");
    repeat (4) fill_op(1'b0, "R5 random skip locked");
    reg_op(1'b0, 32'h0, 1'b1, 1'b0, 1'b0, "R1 R8 readback");
    reg_op(1'b1, 32'h1234_567F, 1'b0, 1'b0, 1'b1, "R9 R10 user write");
    reg_op(1'b0, 32'h0, 1'b0, 1'b0, 1'b1, "R9 R10 user read");
    reg_op(1'b1, 32'h0000_000E, 1'b1, 1'b1, 1'b0, "R9 R10 ns write disabled");
    reg_op(1'b0, 32'h0, 1'b1, 1'b1, 1'b0, "R9 ns read disabled");
    reg_op(1'b1, 32'h0000_000F, 1'b1, 1'b1, 1'b1, "R9 ns write enabled");
    reg_op(1'b0, 32'h0, 1'b1, 1'b1, 1'b1, "R7 R9 ns read all locked");
    repeat (2) fill_op(1'b1, "R6 all locked rr");
    repeat (3) fill_op(1'b0, "R6 all locked random");
    reg_op(1'b1, 32'hFFFF_FFF7, 1'b1, 1'b0, 1'b0, "R7 R8 lock 0-2");
    fill_op(1'b1, "R2 R7 only way 3");
    reg_op(1'b1, 32'h0000_0000, 1'b1, 1'b0, 1'b0, "R1 clear");
    repeat (8) fill_op(1'b0, "R5 random unlocked");
    for (int i = 0; i < 400; i++) begin
      int unsigned k = $urandom_range(0, 9);
      if (k < 3)
        reg_op(1'($urandom), $urandom, 1'($urandom_range(0, 3) != 0), 1'($urandom),
               1'($urandom), "R1 R9 R10 random reg");
      else
        fill_op(1'($urandom), "R2 R4 R5 R6 random fill");
      if ($urandom_range(0, 5) == 0) @(negedge clk);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule